// File: doc/BRIEF.md
# Watchdog Timer with Programmable Prescaler

This block watches a small processor core and asks for a reset when the software stops servicing it. It counts ticks from one of two sources, chosen by a static parameter. One source is a strobe from a dedicated low-speed oscillator. The other is the instruction-clock strobe, which is gated off while the core is halted. The ticks first pass through a fixed binary pre-divider of `PRE_STAGES` stages. A prescaler then divides further by 1, 2, 4 and so on up to 128, as set by a 3-bit select field.

Software restarts the count with clear strobes. A static parameter picks the clear mode. In single mode, one clear instruction is enough. In dual mode, two different clear instructions must both be seen, in either order or in the same cycle. A halt instruction also restarts the count.

When the count expires, the block gives a one-cycle time-out pulse and sets a sticky time-out flag. If the core is running, it also requests a full chip reset. If the core is halted, it requests a warm reset instead, which zeroes only the program counter and stack pointer. An 8-bit control register holds the select field and five user flag bits. The flag bits are plain storage. All interfaces are plain control and status pins; the block carries no data stream.

Top module: `watchdog_timer`

## Requirements
- R1: After reset, `ctrl_rdata` reads 8'h87: flag bits [7:3] = 10000 and select bits [2:0] = 111. All output pulses and `to_flag` are low.
- R2: With a tick in every cycle, the time-out pulse comes exactly 2^(PRE_STAGES+s) ticks after a counter restart, where s is the active select value. Select 111 gives 1:128. The pulse lasts one cycle, and the count then wraps to zero and starts the next period.
- R3: With `SRC = SRC_OSC`, the block counts `osc_tick`. With `SRC = SRC_INSTR`, it counts `instr_tick` only while `halted` is low, so no time-out can occur during halt.
- R4: A write to select bits [2:0] does not change the running period. It takes effect at the next restart: a clear, a halt instruction or an overflow.
- R5: In single clear mode, `clr_a` restarts the counter and `clr_b` has no effect.
- R6: In dual clear mode, the counter restarts only once both `clr_a` and `clr_b` have been seen, in either order or together. The record of seen strobes is dropped on every restart.
- R7: `halt_cmd` restarts the counter and prescaler.
- R8: An overflow while `halted` is low pulses `chip_rst_req` for one cycle and sets `to_flag`.
- R9: An overflow while `halted` is high pulses `warm_rst_req` instead of `chip_rst_req`. The two requests are never high together.
- R10: `to_flag` is cleared by `halt_cmd` or by an effective clear.
- R11: The control register stores all eight written bits and reads them back on `ctrl_rdata` from the cycle after the write.
- R12: A restart in the same cycle as the terminal tick wins: no time-out pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| osc_tick | input | 1 | Tick strobe from the dedicated watchdog oscillator |
| instr_tick | input | 1 | Instruction-clock tick strobe |
| halted | input | 1 | Core is in the halt state |
| clr_a | input | 1 | First clear instruction strobe |
| clr_b | input | 1 | Second clear instruction strobe |
| halt_cmd | input | 1 | Halt instruction strobe |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register contents |
| timeout_pulse | output | 1 | One-cycle pulse on counter expiry |
| warm_rst_req | output | 1 | Warm reset request (overflow during halt) |
| chip_rst_req | output | 1 | Full chip reset request (overflow while running) |
| to_flag | output | 1 | Sticky time-out flag |

## Verification
Every result is registered once. The time-out pulse and the two reset requests appear in the cycle after the edge that sees the terminal tick. A restart empties the counter at its own edge, so the first pulse after a restart arrives 2^(PRE_STAGES+s) cycles later when there is a tick every cycle. A register write becomes visible on `ctrl_rdata` one cycle after the write.

The bench drives inputs just after a rising edge. It advances its reference model for that same edge and compares all outputs 1 ns after the edge, so each check lands in the cycle where the result is due. Directed runs also count cycles between a restart and the pulse and compare the count with the computed period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    SRC_OSC   = 1'b0,
    SRC_INSTR = 1'b1
  } wdt_src_e;

  typedef enum logic {
    CLR_SINGLE = 1'b0,
    CLR_DUAL   = 1'b1
  } wdt_clr_e;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned FLAG_W  = CTRL_W - SEL_W;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [SEL_W-1:0]  sel;
  } wdt_ctrl_t;

  localparam wdt_ctrl_t CTRL_RST = '{flags: 5'b10000, sel: 3'b111};

endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src
  import wdt_pkg::*;
#(
  parameter wdt_src_e SRC = SRC_OSC
) (
  input  logic osc_tick,
  input  logic instr_tick,
  input  logic halted,
  output logic tick
);

  // Instruction clock is gated off while the core is halted.
  always_comb begin
    if (SRC == SRC_OSC) tick = osc_tick;
    else                tick = instr_tick & ~halted;
  end

endmodule

// File: rtl/wdt_clr_ctrl.sv
module wdt_clr_ctrl
  import wdt_pkg::*;
#(
  parameter wdt_clr_e CLR_MODE = CLR_SINGLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_a,
  input  logic clr_b,
  input  logic flush,   // any other restart cause
  output logic fire
);

  generate
    if (CLR_MODE == CLR_DUAL) begin : g_dual
      logic seen_a_q, seen_b_q;

      assign fire = (seen_a_q | clr_a) & (seen_b_q | clr_b);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seen_a_q <= 1'b0;
          seen_b_q <= 1'b0;
        end else if (fire || flush) begin
          seen_a_q <= 1'b0;
          seen_b_q <= 1'b0;
        end else begin
          seen_a_q <= seen_a_q | clr_a;
          seen_b_q <= seen_b_q | clr_b;
        end
      end
    end else begin : g_single
      logic unused_single;
      assign fire          = clr_a;
      assign unused_single = clr_b ^ flush ^ clk ^ rst_n;
    end
  endgenerate

endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel_in,
  output logic             ovf,
  output logic [SEL_W-1:0] sel_act
);

  // Pre-divider and prescaler share one binary counter; the active
  // width of the terminal compare grows with the select value.
  localparam int unsigned CW = PRE_W + MAX_SEL;

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    mask;
  logic [SEL_W-1:0] sel_q;
  logic             term;
  logic             restart;

  genvar g;
  generate
    for (g = 0; g < CW; g++) begin : g_mask
      assign mask[g] = (32'(g) < (32'(PRE_W) + 32'(sel_q)));
    end
  endgenerate

  assign term    = &(cnt_q | ~mask);
  assign ovf     = tick & term & ~clear;
  assign restart = clear | ovf;
  assign sel_act = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= CTRL_RST.sel;
    end else if (restart) begin
      cnt_q <= '0;
      sel_q <= sel_in;     // new ratio only at a restart
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output wdt_ctrl_t         q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= CTRL_RST;
    else if (we) q <= wdt_ctrl_t'(wdata);
  end

endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_STAGES = 8,
  parameter wdt_src_e    SRC        = SRC_OSC,
  parameter wdt_clr_e    CLR_MODE   = CLR_SINGLE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       instr_tick,
  input  logic       halted,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       halt_cmd,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  output logic       timeout_pulse,
  output logic       warm_rst_req,
  output logic       chip_rst_req,
  output logic       to_flag
);

  logic             tick;
  logic             fire;
  logic             clear;
  logic             ovf;
  logic             flush;
  logic [SEL_W-1:0] sel_act;
  wdt_ctrl_t        ctrl_q;

  logic tp_q, warm_q, chip_q, to_q;

  wdt_tick_src #(.SRC(SRC)) u_src (
    .osc_tick   (osc_tick),
    .instr_tick (instr_tick),
    .halted     (halted),
    .tick       (tick)
  );

  wdt_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .wdata (ctrl_wdata),
    .q     (ctrl_q)
  );

  assign flush = halt_cmd | ovf;

  wdt_clr_ctrl #(.CLR_MODE(CLR_MODE)) u_clr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_a (clr_a),
    .clr_b (clr_b),
    .flush (flush),
    .fire  (fire)
  );

  assign clear = fire | halt_cmd;

  wdt_count #(.PRE_W(PRE_STAGES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clear   (clear),
    .sel_in  (ctrl_q.sel),
    .ovf     (ovf),
    .sel_act (sel_act)
  );

  logic unused_sel;
  assign unused_sel = ^sel_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_q   <= 1'b0;
      warm_q <= 1'b0;
      chip_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      tp_q   <= ovf;
      warm_q <= ovf & halted;
      chip_q <= ovf & ~halted;
      if (ovf)        to_q <= 1'b1;
      else if (clear) to_q <= 1'b0;
    end
  end

  assign ctrl_rdata    = ctrl_q;
  assign timeout_pulse = tp_q;
  assign warm_rst_req  = warm_q;
  assign chip_rst_req  = chip_q;
  assign to_flag       = to_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter wdt_src_e SRC      = SRC_OSC,
  parameter wdt_clr_e CLR_MODE = CLR_SINGLE
) (
  input logic clk,
  input logic rst_n,
  input logic halted,
  input logic clr_a,
  input logic clr_b,
  input logic halt_cmd,
  input logic timeout_pulse,
  input logic warm_rst_req,
  input logic chip_rst_req,
  input logic to_flag
);

  p_pulse_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  p_instr_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (SRC == SRC_INSTR && timeout_pulse) |-> !$past(halted));

  p_single_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CLR_MODE == CLR_SINGLE && clr_a) |=> !timeout_pulse);

  p_halt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd |=> !timeout_pulse);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> to_flag);

  p_warm_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |-> $past(halted));

  p_req_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(warm_rst_req && chip_rst_req));

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd |=> !to_flag);

  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a && clr_b) |=> !timeout_pulse);

endmodule

bind watchdog_timer wdt_checker #(.SRC(SRC), .CLR_MODE(CLR_MODE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .halted        (halted),
  .clr_a         (clr_a),
  .clr_b         (clr_b),
  .halt_cmd      (halt_cmd),
  .timeout_pulse (timeout_pulse),
  .warm_rst_req  (warm_rst_req),
  .chip_rst_req  (chip_rst_req),
  .to_flag       (to_flag)
);

// File: tb/watchdog_timer_tb_top.sv
`timescale 1ns/1ps
module watchdog_timer_tb_top;
  import wdt_pkg::*;

  localparam int PRE = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic osc_tick = 0, instr_tick = 0, halted = 0;
  logic clr_a = 0, clr_b = 0, halt_cmd = 0, ctrl_we = 0;
  logic [7:0] ctrl_wdata = '0;

  logic [7:0] rd_i, rd_s;
  logic tp_i, wr_i, cr_i, to_i;
  logic tp_s, wr_s, cr_s, to_s;

  // dut_i: oscillator source, dual clear; dut_s: instruction source, single clear
  watchdog_timer #(.PRE_STAGES(PRE), .SRC(SRC_OSC), .CLR_MODE(CLR_DUAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .instr_tick(instr_tick),
    .halted(halted), .clr_a(clr_a), .clr_b(clr_b), .halt_cmd(halt_cmd),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(rd_i),
    .timeout_pulse(tp_i), .warm_rst_req(wr_i), .chip_rst_req(cr_i), .to_flag(to_i));

  watchdog_timer #(.PRE_STAGES(PRE), .SRC(SRC_INSTR), .CLR_MODE(CLR_SINGLE)) dut_s (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .instr_tick(instr_tick),
    .halted(halted), .clr_a(clr_a), .clr_b(clr_b), .halt_cmd(halt_cmd),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(rd_s),
    .timeout_pulse(tp_s), .warm_rst_req(wr_s), .chip_rst_req(cr_s), .to_flag(to_s));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state, index 0 = dut_i, 1 = dut_s
  int       m_cnt [2];
  bit [2:0] m_sel [2];
  bit [7:0] m_ctrl[2];
  bit       m_pa[2], m_pb[2], m_to[2], m_tp[2], m_wr[2], m_cr[2];

  function automatic int period(input int s);
    return 1 << (PRE + s);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_cnt[k] = 0; m_sel[k] = 3'b111; m_ctrl[k] = 8'h87;
      m_pa[k] = 0; m_pb[k] = 0; m_to[k] = 0; m_tp[k] = 0; m_wr[k] = 0; m_cr[k] = 0;
    end
  endtask

  task automatic model_step(input int k);
    bit osc, dual, tick, fire, clr, ovf;
    osc  = (k == 0);
    dual = (k == 0);
    tick = osc ? osc_tick : (instr_tick & !halted);
    fire = dual ? ((m_pa[k] | clr_a) & (m_pb[k] | clr_b)) : clr_a;
    clr  = fire | halt_cmd;
    ovf  = tick && (m_cnt[k] == period(int'(m_sel[k])) - 1) && !clr;
    m_tp[k] = ovf;
    m_cr[k] = ovf & !halted;
    m_wr[k] = ovf & halted;
    if (ovf) m_to[k] = 1;
    else if (clr) m_to[k] = 0;
    if (clr || ovf) begin
      m_cnt[k] = 0; m_sel[k] = m_ctrl[k][2:0]; m_pa[k] = 0; m_pb[k] = 0;
    end else begin
      if (tick) m_cnt[k]++;
      if (dual) begin m_pa[k] |= clr_a; m_pb[k] |= clr_b; end
    end
    if (ctrl_we) m_ctrl[k] = ctrl_wdata;
  endtask

  task automatic compare();
    check(tp_i == m_tp[0], "R6 timeout dual", tp_i, m_tp[0]);
    check(tp_s == m_tp[1], "R5 timeout single", tp_s, m_tp[1]);
    check(cr_i == m_cr[0], "R8 chip_i", cr_i, m_cr[0]);
    check(cr_s == m_cr[1], "R8 chip_s", cr_s, m_cr[1]);
    check(wr_i == m_wr[0], "R9 warm_i", wr_i, m_wr[0]);
    check(wr_s == m_wr[1], "R9 warm_s", wr_s, m_wr[1]);
    check(to_i == m_to[0], "R10 flag_i", to_i, m_to[0]);
    check(to_s == m_to[1], "R10 flag_s", to_s, m_to[1]);
    check(rd_i == m_ctrl[0], "R11 rdata_i", rd_i, m_ctrl[0]);
    check(rd_s == m_ctrl[1], "R11 rdata_s", rd_s, m_ctrl[1]);
  endtask

  // one clock: model advances on the same edge, outputs compared 1 ns later
  task automatic cycle();
    @(posedge clk);
    model_step(0);
    model_step(1);
    #1;
    compare();
  endtask

  task automatic write_ctrl(input bit [7:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    cycle();
    ctrl_we = 0;
  endtask

  // counts cycles until dut_i pulses
  task automatic measure(output int n);
    n = 0;
    do begin cycle(); n++; end while (!tp_i && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, wcnt, ccnt, scnt;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(rd_i == 8'h87 && rd_s == 8'h87, "R1 ctrl reset", rd_i, 8'h87);
    check(!tp_i && !wr_i && !cr_i && !to_i && !tp_s && !to_s, "R1 outputs reset", tp_i, 0);
    rst_n = 1;

    // R7 / R2: period after halt clear with tick every cycle
    osc_tick = 1; instr_tick = 1;
    write_ctrl(8'h80);
    halt_cmd = 1; cycle(); halt_cmd = 0;
    measure(n);
    check(n == period(0), "R7 first period after halt clear", n, period(0));
    measure(n);
    check(n == period(0), "R2 wrapped period sel0", n, period(0));

    // R4: new select waits for next restart
    write_ctrl(8'h82);
    n = 1;
    while (!tp_i && n < 5000) begin cycle(); n++; end
    check(n == period(0), "R4 old ratio kept", n, period(0));
    measure(n);
    check(n == period(2), "R4 new ratio after overflow", n, period(2));

    // R3 / R9: halted, oscillator keeps running, instruction source frozen
    halted = 1;
    wcnt = 0; ccnt = 0; scnt = 0;
    for (int i = 0; i < 40; i++) begin
      cycle();
      wcnt += wr_i; ccnt += cr_i; scnt += tp_s;
    end
    check(wcnt >= 2, "R9 warm requests in halt", wcnt, 2);
    check(ccnt == 0, "R9 no chip request in halt", ccnt, 0);
    check(scnt == 0, "R3 instr source frozen in halt", scnt, 0);
    halted = 0;

    // R12: clear on the terminal cycle wins
    halt_cmd = 1; cycle(); halt_cmd = 0;
    for (int i = 0; i < period(2) - 1; i++) cycle();
    clr_a = 1; clr_b = 1; cycle(); clr_a = 0; clr_b = 0;
    check(tp_i == 0 && tp_s == 0, "R12 clear beats terminal", tp_i, 0);
    measure(n);
    check(n == period(2), "R6 dual clear restarts count", n, period(2));

    // R11: flag bits are plain storage
    write_ctrl(8'h5A);
    check(rd_i == 8'h5A && rd_s == 8'h5A, "R11 readback", rd_i, 8'h5A);

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      osc_tick   = ($urandom % 4) != 0;
      instr_tick = ($urandom % 3) != 0;
      if ($urandom % 150 == 0) halted = ~halted;
      clr_a    = ($urandom % 30) == 0;
      clr_b    = ($urandom % 30) == 0;
      halt_cmd = ($urandom % 200) == 0;
      ctrl_we  = ($urandom % 120) == 0;
      ctrl_wdata = {5'($urandom), 3'($urandom % 4)};
      cycle();
    end
    clr_a = 0; clr_b = 0; halt_cmd = 0; ctrl_we = 0;
    cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule